// File: doc/BRIEF.md
# Masked interrupt pending controller

This block gathers up to eight device interrupt requests into one level-sensitive interrupt line for a processor. Each device sets or removes its pending bit through bit-vector inputs: a post vector sets bits and a clear vector removes them. A host port lets software program the mask, read the mask and the pending state back, and retire one pending source by writing its bit index.

The mask register keeps its inverse. A written byte is stored complemented as an enable vector, and a mask read complements it again. The interrupt output is high whenever at least one pending bit is also enabled. It is evaluated again after every change to either register, so unmasking a source that is already pending raises the line at once. Priority, vectoring, cascading and trigger-mode selection are not part of the block.

Top module: `irq_pend_ctl`

## Requirements
- R1: After reset the pending register is 0, the enable vector is 0 (so a mask read returns 0xFF), and irqOut is low.
- R2: A host write to address 0 stores the bitwise inverse of hostWrData as the enable vector. A read of address 0 returns the inverse of the enable vector, which is the byte last written, zero-extended to 64 bits.
- R3: irqOut is high exactly when the pending register ANDed with the enable vector is nonzero. It follows register changes in the cycle after the write or post that caused them.
- R4: A mask write that enables a bit that is already pending raises irqOut in the next cycle. A mask write that disables every pending bit lowers it.
- R5: A post vector ORs its set bits into the pending register on the next clock edge, whatever the mask is.
- R6: A clear vector removes its set bits from the pending register. When post and clear (or an acknowledge) name the same bit in the same cycle, post wins and the bit stays set.
- R7: A host write to address 2 clears the pending bit whose index is hostWrData[3:0]. Bits [7:4] of the written byte are ignored.
- R8: An acknowledge with an index from 8 to 15 leaves the pending register unchanged.
- R9: A read of address 1 returns the pending register in bits [7:0], with bits [63:8] zero. A read of address 3 returns 0, and a write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| postVec | input | 8 | Device bits to set pending |
| clearVec | input | 8 | Device bits to clear pending |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | 2 | Host address: 0 mask, 1 status, 2 acknowledge |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 64 | Host read data for hostAddr, combinational |
| irqOut | output | 1 | Level interrupt to the processor |

## Verification
The bench first raises a source while it is masked, then unmasks it, to catch a design that only evaluates the output when a post arrives; such a design would stay silent until the next post. It writes acknowledges with a nonzero upper nibble and with indices 8 to 15. A design that decodes the whole byte would miss the clear, and one that wraps the index would clear the wrong bit. It drives post together with clear and with an acknowledge on the same bit, to expose a design where the removal wins. It reads the status register with sticky upper bits in mind and checks that a mask read gives back exactly the written byte, not the stored inverse.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int NUM_SRC = 8;
  localparam int ACK_IDX_W = 4;

  typedef struct packed {
    logic                 maskWr;
    logic                 ackWr;
    logic [ACK_IDX_W-1:0] ackIdx;
    logic [NUM_SRC-1:0]   wrByte;
  } ctlStrobe_t;
endpackage

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pend_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int MASK_ADDR = 0,
  parameter int ACK_ADDR = 2
) (
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [NUM_SRC-1:0] hostWrData,
  output ctlStrobe_t        stb
);
  always_comb begin
    stb.maskWr = hostWrEn && (hostAddr == ADDR_W'(MASK_ADDR));
    stb.ackWr  = hostWrEn && (hostAddr == ADDR_W'(ACK_ADDR));
    stb.ackIdx = hostWrData[ACK_IDX_W-1:0];
    stb.wrByte = hostWrData;
  end
endmodule

// File: rtl/irq_pend_dp.sv
module irq_pend_dp
  import irq_pend_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         stb,
  input  logic [NUM_SRC-1:0] postVec,
  input  logic [NUM_SRC-1:0] clearVec,
  output logic [NUM_SRC-1:0] pendReg,
  output logic [NUM_SRC-1:0] enableReg,
  output logic               irqOut
);
  logic [NUM_SRC-1:0] ackHit;
  logic [NUM_SRC-1:0] pendNext;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_ack
    assign ackHit[i] = stb.ackWr && (stb.ackIdx == ACK_IDX_W'(i));
  end

  assign pendNext = (pendReg & ~clearVec & ~ackHit) | postVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendReg   <= '0;
      enableReg <= '0;
    end else begin
      pendReg <= pendNext;
      if (stb.maskWr) enableReg <= ~stb.wrByte;
    end
  end

  assign irqOut = |(pendReg & enableReg);
endmodule

// File: rtl/irq_pend_ctl.sv
module irq_pend_ctl
  import irq_pend_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int RD_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        postVec,
  input  logic [7:0]        clearVec,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostWrData,
  output logic [RD_W-1:0]   hostRdData,
  output logic              irqOut
);
  localparam int MASK_ADDR = 0;
  localparam int STAT_ADDR = 1;
  localparam int ACK_ADDR  = 2;

  ctlStrobe_t         stb;
  logic [NUM_SRC-1:0] pendReg;
  logic [NUM_SRC-1:0] enableReg;

  irq_pend_ctrl #(.ADDR_W(ADDR_W), .MASK_ADDR(MASK_ADDR), .ACK_ADDR(ACK_ADDR)) uCtrl (
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData), .stb(stb)
  );

  irq_pend_dp uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .postVec(postVec), .clearVec(clearVec),
    .pendReg(pendReg), .enableReg(enableReg), .irqOut(irqOut)
  );

  always_comb begin
    hostRdData = '0;
    if (hostAddr == ADDR_W'(MASK_ADDR)) hostRdData[NUM_SRC-1:0] = ~enableReg;
    else if (hostAddr == ADDR_W'(STAT_ADDR)) hostRdData[NUM_SRC-1:0] = pendReg;
  end
endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] postVec,
  input logic [7:0] clearVec,
  input logic       hostWrEn,
  input logic [1:0] hostAddr,
  input logic [7:0] hostWrData,
  input logic       irqOut,
  input logic [7:0] pendReg,
  input logic [7:0] enableReg
);
  a_r2_mask_inverted: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == 2'd0) |=> (enableReg == ~$past(hostWrData)));

  a_r5_post_sets: assert property (@(posedge clk) disable iff (!rstN)
    (postVec != 8'h0) |=> ((pendReg & $past(postVec)) == $past(postVec)));

  a_r6_clear_removes: assert property (@(posedge clk) disable iff (!rstN)
    ((clearVec & ~postVec) != 8'h0) |=> ((pendReg & $past(clearVec & ~postVec)) == 8'h0));

  a_r8_high_ack_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == 2'd2 && hostWrData[3] && postVec == 8'h0 && clearVec == 8'h0)
    |=> $stable(pendReg));

  a_r3_irq_stable: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(pendReg) && $stable(enableReg)) |-> $stable(irqOut));

  a_r3_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (enableReg == 8'h0) |-> !irqOut);
endmodule

bind irq_pend_ctl irq_pend_chk uChk (
  .clk(clk), .rstN(rstN), .postVec(postVec), .clearVec(clearVec),
  .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData),
  .irqOut(irqOut), .pendReg(pendReg), .enableReg(enableReg)
);

// File: tb/irq_pend_ctl_test.sv
`timescale 1ns/1ps
module irq_pend_ctl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  postVec = '0;
  logic [7:0]  clearVec = '0;
  logic        hostWrEn = 1'b0;
  logic [1:0]  hostAddr = '0;
  logic [7:0]  hostWrData = '0;
  logic [63:0] hostRdData;
  logic        irqOut;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  irq_pend_ctl uut (
    .clk(clk), .rstN(rstN), .postVec(postVec), .clearVec(clearVec),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .irqOut(irqOut)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic pulse(logic [7:0] p, logic [7:0] c);
    @(negedge clk);
    postVec = p; clearVec = c;
    @(negedge clk);
    postVec = '0; clearVec = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [63:0] d);
    hostAddr = a;
    #1 d = hostRdData;
  endtask

  task automatic t_reset;
    logic [63:0] d;
    rd(2'd1, d); chk("R1 pending", d, 64'h0);
    rd(2'd0, d); chk("R1 mask", d, 64'hFF);
    chk("R1 irq", irqOut, 1'b0);
  endtask

  task automatic t_mask_rw;
    logic [63:0] d;
    wr(2'd0, 8'h5A);
    rd(2'd0, d); chk("R2 mask readback", d, 64'h5A);
    wr(2'd0, 8'hFF);
    rd(2'd0, d); chk("R2 mask all", d, 64'hFF);
  endtask

  task automatic t_post_masked_then_unmask;
    logic [63:0] d;
    pulse(8'h10, 8'h00);
    rd(2'd1, d); chk("R5 post while masked", d, 64'h10);
    chk("R3 masked no irq", irqOut, 1'b0);
    wr(2'd0, 8'hEF);
    chk("R4 unmask pending raises", irqOut, 1'b1);
    wr(2'd0, 8'hFF);
    chk("R4 remask lowers", irqOut, 1'b0);
  endtask

  task automatic t_post_or_clear;
    logic [63:0] d;
    pulse(8'h03, 8'h00);
    rd(2'd1, d); chk("R5 post ors", d, 64'h13);
    pulse(8'h00, 8'h11);
    rd(2'd1, d); chk("R6 clear", d, 64'h02);
    wr(2'd0, 8'hFD);
    chk("R3 irq enabled pending", irqOut, 1'b1);
    pulse(8'h00, 8'h02);
    chk("R3 irq drops when cleared", irqOut, 1'b0);
    pulse(8'h04, 8'h04);
    rd(2'd1, d); chk("R6 post beats clear", d, 64'h04);
  endtask

  task automatic t_ack;
    logic [63:0] d;
    pulse(8'hC8, 8'h00);
    rd(2'd1, d); chk("R5 setup", d, 64'hCC);
    wr(2'd2, 8'h02);
    rd(2'd1, d); chk("R7 ack idx2", d, 64'hC8);
    wr(2'd2, 8'h73);
    rd(2'd1, d); chk("R7 upper nibble ignored", d, 64'hC0);
    wr(2'd2, 8'h09);
    rd(2'd1, d); chk("R8 idx9 no effect", d, 64'hC0);
    wr(2'd2, 8'h0F);
    rd(2'd1, d); chk("R8 idx15 no effect", d, 64'hC0);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = 2'd2; hostWrData = 8'h07; postVec = 8'h80;
    @(negedge clk);
    hostWrEn = 1'b0; postVec = '0;
    rd(2'd1, d); chk("R6 post beats ack", d, 64'hC0);
  endtask

  task automatic t_reads;
    logic [63:0] d;
    rd(2'd1, d); chk("R9 status zero-extended", d, 64'h00000000000000C0);
    wr(2'd3, 8'h00);
    rd(2'd3, d); chk("R9 addr3 reads zero", d, 64'h0);
    rd(2'd0, d); chk("R9 addr3 write no mask change", d, 64'hFD);
    rd(2'd1, d); chk("R9 addr3 write no pend change", d, 64'hC0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        t_reset();
        t_mask_rw();
        t_post_masked_then_unmask();
        t_post_or_clear();
        t_ack();
        t_reads();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule